// File: doc/BRIEF.md
# Peripheral Clock Control Slice

This block controls the clock and reset of one attached peripheral. One 32-bit control word picks one of several source tick strobes. All sources run in the same system clock domain. The block scales the chosen strobe by a fractional ratio and gates the result onto a single output tick strobe. The same word also carries a release bit for the peripheral's active-low reset.

Software writes the whole word through a single-cycle write port and can read it back at any time. The source and ratio fields are protected. They may only change while the output gate is off, so the scaled tick never switches ratio or source while the peripheral is running. The ratio is built as a phase accumulator. Each selected source tick adds the numerator. Whenever the sum reaches the denominator, the denominator is taken off and one output tick is sent.

Top module: `periph_clk_ctrl`

## Requirements
- R1: After system reset the control word reads 0, `out_tick` is 0 and `periph_rst_n` is 0.
- R2: Read layout. Gate enable is at bit 30 and reset release at bit 28. Source select (3 bits) is at 26:24, numerator code (1 bit) at bit 3 and denominator code (3 bits) at 2:0. Every other bit reads 0.
- R3: A write while the gate bit is 1 leaves the source select, numerator code and denominator code unchanged. The gate and reset-release bits are still written.
- R4: While the gate bit is 0, `out_tick` stays 0 and the phase accumulator is held at zero.
- R5: With the gate on, the ratio is numerator/denominator, where numerator = code+1 (1 or 2) and denominator = code+1 (1 to 8). Each selected source tick adds the numerator to the accumulator. If the sum is at least the denominator, the denominator is subtracted and one output tick is produced.
- R6: Ticks on source inputs other than the selected one have no effect on `out_tick`.
- R7: When numerator exceeds denominator, the block emits exactly one output tick per selected source tick and never more.
- R8: `periph_rst_n` equals the reset-release bit. It changes in the cycle after the write.
- R9: A single write that clears the gate and changes other fields turns the gate off but leaves those fields at their old values. A second write, made with the gate off, is needed to change them.
- R10: An output tick appears in the cycle after the clock edge at which the selected source tick was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control word |
| src_tick | input | 8 | Source tick strobes, one per selectable source |
| out_tick | output | 1 | Scaled and gated tick strobe |
| periph_rst_n | output | 1 | Active-low reset to the attached peripheral |

## Verification
The bench builds the block with its default widths: a 3-bit source select (eight sources), a 1-bit numerator code and a 3-bit denominator code. With these widths every numerator/denominator pair can be reached, including the case where the numerator exceeds a denominator of 1 and the output must clamp. Every source index can be reached as well. Random writes flip the gate often enough to reach both locked and unlocked updates and the gate-clearing write that changes other fields.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   // Field positions that software decodes; fixed by the register layout.
   localparam int GATE_BIT = 30;
   localparam int REL_BIT  = 28;
   localparam int SEL_LSB  = 24;
   localparam int FRAC_LSB = 3;
   localparam int DIV_LSB  = 0;
   localparam int WORD_W   = 32;
endpackage

// File: rtl/pcc_regs.sv
module pcc_regs
   import pcc_pkg::*;
#(
   parameter int SEL_W  = 3,
   parameter int FRAC_W = 1,
   parameter int DIV_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              gate,
   output logic              rel,
   output logic [SEL_W-1:0]  sel,
   output logic [FRAC_W-1:0] frac,
   output logic [DIV_W-1:0]  div,
   output logic [WORD_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate <= 1'b0;
         rel  <= 1'b0;
         sel  <= '0;
         frac <= '0;
         div  <= '0;
      end else if (wr_en) begin
         gate <= wr_data[GATE_BIT];
         rel  <= wr_data[REL_BIT];
         // Rate and source fields only move while the output is gated off.
         if (!gate) begin
            sel  <= wr_data[SEL_LSB  +: SEL_W];
            frac <= wr_data[FRAC_LSB +: FRAC_W];
            div  <= wr_data[DIV_LSB  +: DIV_W];
         end
      end
   end

   always_comb begin
      rd_data                      = '0;
      rd_data[GATE_BIT]            = gate;
      rd_data[REL_BIT]             = rel;
      rd_data[SEL_LSB  +: SEL_W]   = sel;
      rd_data[FRAC_LSB +: FRAC_W]  = frac;
      rd_data[DIV_LSB  +: DIV_W]   = div;
   end

   // R3: with the gate on, protected fields hold for the next cycle
   p_lock_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gate |=> ($stable(sel) && $stable(frac) && $stable(div)));

   // R9: a gate-clearing write still cannot move protected fields
   p_two_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && wr_en && !wr_data[GATE_BIT]) |=> (!gate && $stable(div) && $stable(sel)));
endmodule

// File: rtl/pcc_src_mux.sv
module pcc_src_mux #(
   parameter int SEL_W = 3,
   localparam int NUM_SRC = 1 << SEL_W
) (
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick_o
);
   logic [NUM_SRC-1:0] hit;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
         assign hit[g] = src_tick[g] && (sel == g[SEL_W-1:0]);
      end
   endgenerate

   assign tick_o = |hit;

   // R6: at most one leg of the AND-OR select is live
   always_comb begin
      a_one_leg_r6: assert ($onehot0(hit));
   end
endmodule

// File: rtl/pcc_frac_div.sv
module pcc_frac_div #(
   parameter int FRAC_W = 1,
   parameter int DIV_W  = 3,
   localparam int ACC_W = ((DIV_W > FRAC_W) ? DIV_W : FRAC_W) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              src_tick,
   input  logic [FRAC_W-1:0] num_code,
   input  logic [DIV_W-1:0]  den_code,
   output logic              tick_o
);
   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] num;
   logic [ACC_W-1:0] den;
   logic [ACC_W-1:0] sum;
   logic             reach;

   assign num   = ACC_W'(num_code) + ACC_W'(1);
   assign den   = ACC_W'(den_code) + ACC_W'(1);
   assign sum   = acc + num;
   assign reach = (sum >= den);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         tick_o <= 1'b0;
      end else if (!en) begin
         acc    <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= src_tick && reach;
         if (src_tick) begin
            if (num > den)  acc <= '0;          // clamp: one tick per source tick
            else if (reach) acc <= sum - den;
            else            acc <= sum;
         end
      end
   end

   // R5: accumulator never holds a full denominator
   p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc < den);

   // R4: gate off clears phase and silences output
   p_gate_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!tick_o && acc == '0));

   // R10: every output tick follows a sampled source tick
   p_tick_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(src_tick && en));
endmodule

// File: rtl/periph_clk_ctrl.sv
module periph_clk_ctrl
   import pcc_pkg::*;
#(
   parameter int SEL_W  = 3,
   parameter int FRAC_W = 1,
   parameter int DIV_W  = 3,
   localparam int NUM_SRC = 1 << SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [31:0]        wr_data,
   output logic [31:0]        rd_data,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic               out_tick,
   output logic               periph_rst_n
);
   generate
      if (SEL_W < 1 || SEL_LSB + SEL_W > REL_BIT)
         $error("source select width does not fit its field");
      if (FRAC_W < 1 || FRAC_LSB + FRAC_W > SEL_LSB)
         $error("numerator width does not fit its field");
      if (DIV_W < 1 || DIV_LSB + DIV_W > FRAC_LSB)
         $error("denominator width does not fit its field");
   endgenerate

   logic              gate;
   logic              rel;
   logic [SEL_W-1:0]  sel;
   logic [FRAC_W-1:0] frac;
   logic [DIV_W-1:0]  div;
   logic              sel_tick;

   pcc_regs #(.SEL_W(SEL_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .gate    (gate),
      .rel     (rel),
      .sel     (sel),
      .frac    (frac),
      .div     (div),
      .rd_data (rd_data)
   );

   pcc_src_mux #(.SEL_W(SEL_W)) u_mux (
      .src_tick (src_tick),
      .sel      (sel),
      .tick_o   (sel_tick)
   );

   pcc_frac_div #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (gate),
      .src_tick (sel_tick),
      .num_code (frac),
      .den_code (div),
      .tick_o   (out_tick)
   );

   assign periph_rst_n = rel;

   // R8: reset release follows the written bit one cycle later
   p_rst_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (periph_rst_n == $past(wr_data[REL_BIT])));

   // R7: never more than one output tick per sampled selected tick
   p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> $past(sel_tick));
endmodule

// File: tb/tb_periph_clk_ctrl.sv
module tb_periph_clk_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [7:0]  src_tick = '0;
   logic        out_tick;
   logic        periph_rst_n;

   int checks = 0;
   int errors = 0;

   // reference state
   bit       m_gate, m_rel, m_frac;
   bit [2:0] m_sel, m_div;
   int       m_acc;
   int       tick_cnt;

   always #10 clk = ~clk;

   periph_clk_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .src_tick(src_tick), .out_tick(out_tick),
      .periph_rst_n(periph_rst_n)
   );

   function automatic logic [31:0] model_word();
      logic [31:0] w = '0;
      w[30] = m_gate; w[28] = m_rel; w[26:24] = m_sel; w[3] = m_frac; w[2:0] = m_div;
      return w;
   endfunction

   function automatic bit model_tick(bit [7:0] t);
      int num = m_frac + 1;
      int den = m_div + 1;
      return m_gate && t[m_sel] && (m_acc + num >= den);
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One clock: drive at falling edge, update model, compare after rising edge.
   task automatic step(bit we, logic [31:0] d, logic [7:0] t, string req);
      bit exp_t;
      int num, den;
      @(negedge clk);
      wr_en = we; wr_data = d; src_tick = t;
      exp_t = model_tick(t);
      num = m_frac + 1; den = m_div + 1;
      if (!m_gate) m_acc = 0;
      else if (t[m_sel]) begin
         if (num > den) m_acc = 0;
         else if (m_acc + num >= den) m_acc = m_acc + num - den;
         else m_acc = m_acc + num;
      end
      if (we) begin
         if (!m_gate) begin
            m_sel = d[26:24]; m_frac = d[3]; m_div = d[2:0];
         end
         m_gate = d[30]; m_rel = d[28];
      end
      @(posedge clk); #1;
      if (out_tick) tick_cnt++;
      chk(out_tick == exp_t, {req, " tick"}, 32'(out_tick), 32'(exp_t));
      chk(rd_data == model_word(), {req, " word"}, rd_data, model_word());
      chk(periph_rst_n == m_rel, "R8 rst", 32'(periph_rst_n), 32'(m_rel));
   endtask

   function automatic logic [31:0] cfg(bit g, bit r, bit [2:0] s, bit f, bit [2:0] dv);
      logic [31:0] w = '0;
      w[30] = g; w[28] = r; w[26:24] = s; w[3] = f; w[2:0] = dv;
      return w;
   endfunction

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", checks);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      repeat (3) @(posedge clk);
      #1;
      chk(rd_data == 0, "R1 word", rd_data, 0);
      chk(out_tick == 0, "R1 tick", 32'(out_tick), 0);
      chk(periph_rst_n == 0, "R1 rst", 32'(periph_rst_n), 0);
      @(negedge clk); rst_n = 1'b1;

      // R2: unused bits ignored and read as zero
      step(1, 32'hFFFF_FFFF & ~(32'h1 << 30), 8'h00, "R2");
      chk(rd_data == 32'h1700_000F, "R2 layout", rd_data, 32'h1700_000F);
      step(1, cfg(0, 1, 3'd2, 1, 3'd2), 8'h00, "R2");

      // R4: gate off, selected ticks give nothing
      for (int i = 0; i < 4; i++) step(0, 0, 8'h04, "R4");
      step(1, cfg(1, 1, 3'd2, 1, 3'd2), 8'h00, "R5");

      // R5 and R10: ratio 2/3 over 24 source ticks -> 16 output ticks
      tick_cnt = 0;
      for (int i = 0; i < 24; i++) step(0, 0, 8'h04, "R10");
      chk(tick_cnt == 16, "R5 count", tick_cnt, 16);

      // R6: other sources only
      tick_cnt = 0;
      for (int i = 0; i < 10; i++) step(0, 0, 8'hFB, "R6");
      chk(tick_cnt == 0, "R6 count", tick_cnt, 0);

      // R3: locked write changes only gate/release
      step(1, cfg(1, 0, 3'd5, 0, 3'd7), 8'h00, "R3");
      chk(rd_data == cfg(1, 0, 3'd2, 1, 3'd2), "R3 locked", rd_data, cfg(1, 0, 3'd2, 1, 3'd2));

      // R9: clearing the gate and changing fields in one write
      step(1, cfg(0, 1, 3'd6, 0, 3'd0), 8'h00, "R9");
      chk(rd_data == cfg(0, 1, 3'd2, 1, 3'd2), "R9 first", rd_data, cfg(0, 1, 3'd2, 1, 3'd2));
      step(1, cfg(0, 1, 3'd6, 1, 3'd0), 8'h00, "R9");
      chk(rd_data == cfg(0, 1, 3'd6, 1, 3'd0), "R9 second", rd_data, cfg(0, 1, 3'd6, 1, 3'd0));

      // R7: 2/1 clamps to one per source tick
      step(1, cfg(1, 1, 3'd6, 1, 3'd0), 8'h00, "R7");
      tick_cnt = 0;
      for (int i = 0; i < 10; i++) step(0, 0, 8'h40, "R7");
      chk(tick_cnt == 10, "R7 count", tick_cnt, 10);

      // Random mix of writes and ticks
      for (int i = 0; i < 3000; i++) begin
         bit we = ($urandom % 8) == 0;
         logic [31:0] d = $urandom;
         step(we, d, 8'($urandom), "R5");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule